// File: doc/BRIEF.md
# Video Lane Capture Assembler

The block takes three serial video lanes, each carrying seven bits per pixel period, and turns them into one parallel payload word per pixel. It runs on a bit-rate clock at seven times the pixel rate, and that clock is assumed to be phase-aligned to the pixel boundary. A frame-align input marks the cycle in which bit 0 of every lane is present. The 21 lane bits carry 18 colour bits together with horizontal sync, vertical sync and data enable. Three slow side-band level signals go through a two-stage synchronizer and are appended above the lane bits, which gives a 24-bit payload.

Each lane is collected in its own shift register. The first bit received ends up in the highest position of that lane's seven-bit group, so the first bit of lane 0 lands at payload bit 6. A phase counter runs from 0 to 6 and restarts on every frame-align. On the edge that captures bit 6 of a pixel, the full word is registered and a one-cycle valid strobe is raised. The word then stays unchanged until the next strobe. The side-band inputs should only change at less than a fifth of the pixel rate, so a capture position that is off by up to one pixel period does no harm.

Top module: `video_lane_assembler`

## Requirements
- R1: While reset is active and in the cycles just after it is released, `payload_valid` is 0 and `payload` is all zeros.
- R2: Until the first `frame_align` pulse is seen, `payload_valid` never rises and `payload` stays all zeros.
- R3: After alignment, `payload_valid` is high for exactly one bit clock in every seven. That cycle follows the rising edge that samples bit 6, where the bit sampled together with `frame_align` is bit 0.
- R4: Bit i of lane L (i = 0 is the first bit, sampled with `frame_align`) appears at payload bit L*7 + 6 - i. So the first bit of lane 0 is at bit 6, and the last bit of lane 2 is at bit 14.
- R5: Side-band input j appears at payload bit 21 + j. The captured value is the level present at the rising edge of bit 4 of that pixel. A change that arrives after that edge shows up one word later.
- R6: Between two valid strobes, `payload` does not change.
- R7: A `frame_align` pulse in the middle of a word throws away the partial word and makes the current bit bit 0 again. The next strobe follows six edges later.
- R8: Lanes are independent of one another. Patterns that differ per lane, including all-ones, all-zeros and alternating bits, come through unmixed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit-rate clock, seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| frame_align | input | 1 | High in the cycle that carries bit 0 of every lane |
| lane_data | input | 3 | One serial bit per lane for each bit clock |
| side_band | input | 3 | Slow level inputs, synchronized inside the block |
| payload | output | 24 | Assembled pixel word: side-band in bits 23..21, lanes in bits 20..0 |
| payload_valid | output | 1 | One-cycle strobe when a new word is placed on `payload` |

## Verification
The bench uses the default parameters: three lanes of seven bits and three side-band inputs. With these values the fixed bit positions can be checked bit by bit, for example the first bit of lane 0 at position 6 and lane 2's group ending at 14. The seven-cycle strobe spacing is observable at every edge. Because the synchronizer has two stages, the side-band capture point falls exactly at bit 4, so a level change on bit 4 and on bit 5 must give different payloads. A mid-word realignment is also reachable, and it shows whether the partial word is discarded.

// File: rtl/vla_pkg.sv
package vla_pkg;
  localparam int unsigned DEF_LANES   = 3;
  localparam int unsigned DEF_BITS    = 7;
  localparam int unsigned DEF_SB      = 3;
  localparam int unsigned DEF_SYNC    = 2;

  function automatic int unsigned payload_width(input int unsigned lanes,
                                                input int unsigned bits,
                                                input int unsigned sb);
    return lanes * bits + sb;
  endfunction
endpackage

// File: rtl/vla_rst_sync.sv
module vla_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= 2'b00;
    else        chain_q <= {chain_q[0], 1'b1};
  end

  assign rst_n_sync = chain_q[1];
endmodule

// File: rtl/vla_phase_ctr.sv
module vla_phase_ctr #(
  parameter int unsigned BITS = vla_pkg::DEF_BITS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic align_i,
  output logic word_done_o,
  output logic locked_o
);
  localparam int unsigned CW = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic [CW-1:0] cnt_q, cnt_d, idx;
  logic          locked_q, locked_d;

  always_comb begin
    idx         = align_i ? '0 : cnt_q;
    cnt_d       = (idx == LAST) ? '0 : idx + CW'(1);
    locked_d    = locked_q | align_i;
    word_done_o = locked_d && (idx == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      locked_q <= locked_d;
    end
  end

  assign locked_o = locked_q;

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  assert_done_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    word_done_o && !align_i |=> !word_done_o || align_i);

  assert_realign_R7: assert property (@(posedge clk) disable iff (!rst_n)
    align_i |=> (cnt_q == CW'(1 % BITS)));
endmodule

// File: rtl/vla_lane_shift.sv
module vla_lane_shift #(
  parameter int unsigned BITS = vla_pkg::DEF_BITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_i,
  output logic [BITS-1:0] word_o
);
  logic [BITS-2:0] sr_q, sr_d;

  always_comb begin
    sr_d   = {sr_q[BITS-3:0], bit_i};
    word_o = {sr_q, bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end
endmodule

// File: rtl/vla_sb_sync.sv
module vla_sb_sync #(
  parameter int unsigned WIDTH  = vla_pkg::DEF_SB,
  parameter int unsigned STAGES = vla_pkg::DEF_SYNC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = async_i;
      end else begin : g_next
        always_comb stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/video_lane_assembler.sv
module video_lane_assembler #(
  parameter int unsigned LANES = vla_pkg::DEF_LANES,
  parameter int unsigned BITS  = vla_pkg::DEF_BITS,
  parameter int unsigned SB    = vla_pkg::DEF_SB,
  parameter int unsigned PW    = vla_pkg::payload_width(LANES, BITS, SB)
) (
  input  logic             bit_clk,
  input  logic             rst_n,
  input  logic             frame_align,
  input  logic [LANES-1:0] lane_data,
  input  logic [SB-1:0]    side_band,
  output logic [PW-1:0]    payload,
  output logic             payload_valid
);
  localparam int unsigned LANE_W = LANES * BITS;

  logic              rst_n_s;
  logic              word_done, locked;
  logic [LANE_W-1:0] lane_word;
  logic [SB-1:0]     sb_sync;
  logic [PW-1:0]     payload_q, payload_d;
  logic              valid_q, valid_d;

  vla_rst_sync u_rst (
    .clk        (bit_clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  vla_phase_ctr #(.BITS(BITS)) u_ctr (
    .clk         (bit_clk),
    .rst_n       (rst_n_s),
    .align_i     (frame_align),
    .word_done_o (word_done),
    .locked_o    (locked)
  );

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      vla_lane_shift #(.BITS(BITS)) u_lane (
        .clk    (bit_clk),
        .rst_n  (rst_n_s),
        .bit_i  (lane_data[l]),
        .word_o (lane_word[l*BITS +: BITS])
      );
    end
  endgenerate

  vla_sb_sync #(.WIDTH(SB), .STAGES(vla_pkg::DEF_SYNC)) u_sb (
    .clk     (bit_clk),
    .rst_n   (rst_n_s),
    .async_i (side_band),
    .sync_o  (sb_sync)
  );

  always_comb begin
    payload_d = payload_q;
    if (word_done) payload_d = {sb_sync, lane_word};
    valid_d = word_done;
  end

  always_ff @(posedge bit_clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      payload_q <= '0;
      valid_q   <= 1'b0;
    end else begin
      payload_q <= payload_d;
      valid_q   <= valid_d;
    end
  end

  assign payload       = payload_q;
  assign payload_valid = valid_q;

  assert_valid_locked_R2: assert property (@(posedge bit_clk) disable iff (!rst_n_s)
    payload_valid |-> locked);

  assert_hold_between_R6: assert property (@(posedge bit_clk) disable iff (!rst_n_s)
    !payload_valid |-> $stable(payload));

  assert_reset_idle_R1: assert property (@(posedge bit_clk)
    !rst_n_s |-> !payload_valid && (payload == '0));
endmodule

// File: tb/tb_video_lane_assembler.sv
module tb_video_lane_assembler;
  localparam int LANES = 3;
  localparam int BITS  = 7;
  localparam int SB    = 3;
  localparam int PW    = LANES * BITS + SB;

  logic             bit_clk = 1'b0;
  logic             rst_n;
  logic             frame_align;
  logic [LANES-1:0] lane_data;
  logic [SB-1:0]    side_band;
  logic [PW-1:0]    payload;
  logic             payload_valid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [PW-1:0] prev_pay;

  video_lane_assembler dut (
    .bit_clk       (bit_clk),
    .rst_n         (rst_n),
    .frame_align   (frame_align),
    .lane_data     (lane_data),
    .side_band     (side_band),
    .payload       (payload),
    .payload_valid (payload_valid)
  );

  always #10 bit_clk = ~bit_clk;

  task automatic check(input string req, input logic [PW-1:0] act,
                       input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One word: lane L bit i = d[L*7+6-i]; side band old, switches to new
  // while bit chg is presented.
  task automatic do_word(input logic [20:0] d, input logic [2:0] sb_old,
                         input logic [2:0] sb_new, input int chg,
                         input bit align, input bit exp_valid);
    logic [2:0]    sb_exp;
    logic [PW-1:0] exp_pay;
    sb_exp  = (chg <= 4) ? sb_new : sb_old;
    exp_pay = {sb_exp, d};
    for (int i = 0; i < BITS; i++) begin
      @(negedge bit_clk);
      frame_align = align && (i == 0);
      for (int l = 0; l < LANES; l++) lane_data[l] = d[l*BITS + 6 - i];
      side_band = (i >= chg) ? sb_new : sb_old;
      @(posedge bit_clk);
      #2;
      if (i < BITS - 1) begin
        check("R3 valid low mid-word", {23'd0, payload_valid}, '0);
        check("R6 payload held", payload, prev_pay);
      end else begin
        check("R3 valid at bit 6", {23'd0, payload_valid}, {23'd0, exp_valid});
        if (exp_valid) begin
          check("R4/R5 payload word", payload, exp_pay);
          prev_pay = exp_pay;
        end else begin
          check("R2 payload unchanged", payload, prev_pay);
        end
      end
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; frame_align = 1'b0; lane_data = '0; side_band = '0;
    repeat (3) @(posedge bit_clk);
    #2;
    check("R1 valid in reset", {23'd0, payload_valid}, '0);
    check("R1 payload in reset", payload, '0);
    @(negedge bit_clk); rst_n = 1'b1;
    repeat (4) @(posedge bit_clk);
    #2;
    check("R1 valid after release", {23'd0, payload_valid}, '0);
    check("R1 payload after release", payload, '0);
    prev_pay = '0;
  endtask

  task automatic t_unlocked;
    do_word(21'h1FFFFF, 3'b111, 3'b111, 0, 1'b0, 1'b0);
    do_word(21'h0ABCDE, 3'b101, 3'b101, 0, 1'b0, 1'b0);
    check("R2 payload before align", payload, '0);
  endtask

  task automatic t_patterns;
    do_word(21'h000040, 3'b000, 3'b000, 0, 1'b1, 1'b1); // R4 lane0 first bit -> 6
    do_word(21'h004000, 3'b000, 3'b000, 0, 1'b0, 1'b1); // R4 lane2 last bit -> 14
    do_word(21'h1FFFFF, 3'b001, 3'b001, 0, 1'b0, 1'b1); // R8 all ones, R5 sb0
    do_word(21'h000000, 3'b010, 3'b010, 0, 1'b0, 1'b1); // R8 all zeros, R5 sb1
    do_word(21'h155555, 3'b100, 3'b100, 0, 1'b1, 1'b1); // R8 alternating, R5 sb2
    do_word(21'h0FE07F, 3'b011, 3'b011, 0, 1'b0, 1'b1); // R8 per-lane differ
    do_word(21'h123456, 3'b110, 3'b110, 0, 1'b0, 1'b1);
  endtask

  task automatic t_sideband_timing;
    do_word(21'h00000F, 3'b000, 3'b111, 4, 1'b0, 1'b1); // R5 change at bit 4 taken
    do_word(21'h0000F0, 3'b111, 3'b000, 5, 1'b0, 1'b1); // R5 change at bit 5 late
    do_word(21'h000F00, 3'b000, 3'b000, 0, 1'b0, 1'b1); // R5 appears next word
  endtask

  task automatic t_realign;
    for (int i = 0; i < 3; i++) begin
      @(negedge bit_clk);
      frame_align = 1'b0; lane_data = 3'b111;
      @(posedge bit_clk);
      #2;
      check("R7 valid low partial", {23'd0, payload_valid}, '0);
    end
    do_word(21'h0A5A5A, 3'b010, 3'b010, 0, 1'b1, 1'b1); // R7 restart at bit 0
    do_word(21'h15A5A5, 3'b001, 3'b001, 0, 1'b0, 1'b1);
  endtask

  initial begin
    t_reset();
    t_unlocked();
    t_patterns();
    t_sideband_timing();
    t_realign();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule